// File: doc/BRIEF.md
# Triple Timer Register Bank

This block is the register front end of a three-channel timer. A single bus target takes requests through a plain valid/write/address/data port. It keeps each channel's configuration: clock control, counter control, interval, three match values, interrupt enable and event control. The configuration is driven out to the per-channel counting logic, which sits outside this block. Each counter sends back its running count, its event value and one-cycle event pulses. The bank collects those pulses into a sticky interrupt status word for each channel and drives one interrupt line per channel.

The address map is interleaved. Every register kind takes three consecutive words, one for each channel. The channel is therefore the word index modulo three, and the register kind is the word index divided by three. A read returns its data one cycle after the request. Reading a channel's status word returns its value and clears it in the same step. An event that arrives while that read is taking place is kept.

Top module: `tri_timer_regs`

## Requirements
- R1: For an aligned byte offset A below 0x84, the channel is (A/4) mod 3 and the register kind is (A/4) div 3. The kinds are numbered 0 clock control, 1 counter control, 2 counter value, 3 interval, 4 to 6 matches one to three, 7 interrupt status, 8 interrupt enable, 9 event control and 10 event value.
- R2: A write stores bits [5:0] of clock control and of interrupt enable, bits [2:0] of event control, and bits [15:0] of interval and of the matches. Reads return the stored value zero-extended, and the same value appears on the channel's configuration output.
- R3: Counter control stores write bits [5,3:0] and always reads bit 4 as 0. A write with bit 4 set raises that channel's restart output for the single cycle that follows the write.
- R4: After reset, counter control holds 0x21 in every channel. Every other stored register is zero, all interrupt lines are low and there is no read response.
- R5: The read response valid is high exactly in the cycle after a read request, and the read data is presented in that cycle. A write request produces no response.
- R6: A pulse on event input bit k of a channel sets status bit k. Reading the status returns the value held before the read and clears it.
- R7: An event pulse that arrives in the same cycle as a status read of that channel stays set after the clear.
- R8: Each channel's interrupt line is high exactly while (status AND enable) is nonzero.
- R9: Writes to the status, counter value and event value kinds change nothing. Counter value and event value read back the channel's 16-bit input, zero-extended.
- R10: Offsets at or above 0x84, and offsets with bits [1:0] nonzero, read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 16 | Write data (registers are at most 16 bits wide) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| cnt_value | input | 3*16 | Running count of each channel |
| evt_value | input | 3*16 | Event value of each channel |
| evt_set | input | 3*6 | Event pulses, 6 per channel |
| clk_ctrl | output | 3*6 | Clock control of each channel |
| cnt_ctrl | output | 3*6 | Counter control of each channel |
| cnt_restart | output | 3 | One-cycle restart pulse for each channel |
| interval | output | 3*16 | Interval of each channel |
| match_val | output | 3*3*16 | Three match values per channel |
| evt_ctrl | output | 3*3 | Event control of each channel |
| irq | output | 3 | Interrupt line of each channel |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a new event pulse on the same channel. Both must meet at one clock edge. The bench first leaves a known bit pending. It then drives the read request and a different event bit on the same falling edge. It expects the old value on the bus and the new bit still set on the next read. The remaining register behaviour comes from a full sweep that writes every register kind of every channel and reads the whole map back after each write.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
    parameter int NCH       = 3;
    parameter int MATCHES   = 3;
    parameter int CTRL_W    = 6;
    parameter int STAT_W    = 6;
    parameter int ECTL_W    = 3;
    parameter int CNT_W     = 16;
    parameter int RDATA_W   = 32;
    parameter int GRP_COUNT = 11;
    parameter int GRP_W     = 4;
    localparam int CH_W     = $clog2(NCH);
    localparam int RESTART_BIT = 4;
    localparam logic [CTRL_W-1:0] CNT_CTRL_RST  = 6'h21;
    localparam logic [CTRL_W-1:0] CNT_CTRL_MASK = 6'h2F;

    typedef enum logic [GRP_W-1:0] {
        G_CLK  = 4'd0,
        G_CNT  = 4'd1,
        G_VAL  = 4'd2,
        G_IVL  = 4'd3,
        G_M1   = 4'd4,
        G_M2   = 4'd5,
        G_M3   = 4'd6,
        G_STAT = 4'd7,
        G_IEN  = 4'd8,
        G_ECTL = 4'd9,
        G_EVAL = 4'd10,
        G_NONE = 4'd15
    } grp_e;

    typedef struct packed {
        logic [CTRL_W-1:0]               clk_ctrl;
        logic [CTRL_W-1:0]               cnt_ctrl;
        logic                            restart;
        logic [CNT_W-1:0]                interval;
        logic [MATCHES-1:0][CNT_W-1:0]   match;
        logic [STAT_W-1:0]               ien;
        logic [ECTL_W-1:0]               ectl;
        logic [STAT_W-1:0]               stat;
    } chan_st_t;

    typedef struct packed {
        logic               rsp_valid;
        logic [RDATA_W-1:0] rdata;
    } top_st_t;
endpackage

// File: rtl/tri_timer_decode.sv
module tri_timer_decode
    import tri_timer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output grp_e              grp_o,
    output logic [NCH-1:0]    ch_oh_o,
    output logic [CH_W-1:0]   ch_idx_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] quot;
    logic [WORD_W-1:0] rem;

    always_comb begin
        word     = addr_i[ADDR_W-1:2];
        quot     = word / WORD_W'(NCH);
        rem      = word % WORD_W'(NCH);
        grp_o    = G_NONE;
        ch_oh_o  = '0;
        ch_idx_o = '0;
        if (addr_i[1:0] == 2'b00 && quot < WORD_W'(GRP_COUNT)) begin
            grp_o = grp_e'(quot[GRP_W-1:0]);
            for (int c = 0; c < NCH; c++) begin
                if (rem == WORD_W'(c)) begin
                    ch_oh_o[c] = 1'b1;
                    ch_idx_o   = CH_W'(c);
                end
            end
        end
    end

    always_comb begin
        AST_ONE_CHANNEL: assert ($onehot0(ch_oh_o)); // R1
    end
endmodule

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
    import tri_timer_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic                     rd_i,
    input  grp_e                     grp_i,
    input  logic [CNT_W-1:0]         wdata_i,
    input  logic [STAT_W-1:0]        evt_set_i,
    output logic [CTRL_W-1:0]        clk_ctrl_o,
    output logic [CTRL_W-1:0]        cnt_ctrl_o,
    output logic                     restart_o,
    output logic [CNT_W-1:0]         interval_o,
    output logic [MATCHES*CNT_W-1:0] match_o,
    output logic [STAT_W-1:0]        ien_o,
    output logic [ECTL_W-1:0]        ectl_o,
    output logic [STAT_W-1:0]        stat_o,
    output logic                     irq_o
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        if (rd_i && grp_i == G_STAT) begin
            st_d.stat = '0;
        end
        st_d.stat = st_d.stat | evt_set_i;
        if (wr_i) begin
            case (grp_i)
                G_CLK:  st_d.clk_ctrl = wdata_i[CTRL_W-1:0];
                G_CNT: begin
                    st_d.cnt_ctrl = wdata_i[CTRL_W-1:0] & CNT_CTRL_MASK;
                    st_d.restart  = wdata_i[RESTART_BIT];
                end
                G_IVL:  st_d.interval = wdata_i;
                G_IEN:  st_d.ien      = wdata_i[STAT_W-1:0];
                G_ECTL: st_d.ectl     = wdata_i[ECTL_W-1:0];
                default: ;
            endcase
            for (int m = 0; m < MATCHES; m++) begin
                if (int'(grp_i) == int'(G_M1) + m) begin
                    st_d.match[m] = wdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cnt_ctrl <= CNT_CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_ctrl_o = st_q.clk_ctrl;
    assign cnt_ctrl_o = st_q.cnt_ctrl;
    assign restart_o  = st_q.restart;
    assign interval_o = st_q.interval;
    assign match_o    = st_q.match;
    assign ien_o      = st_q.ien;
    assign ectl_o     = st_q.ectl;
    assign stat_o     = st_q.stat;
    assign irq_o      = |(st_q.stat & st_q.ien);

    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && grp_i == G_STAT && evt_set_i == '0) |=> (stat_o == '0)); // R6
    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set_i != '0) |=> ((stat_o & $past(evt_set_i)) == $past(evt_set_i))); // R7
    AST_RESTART_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> $past(wr_i && grp_i == G_CNT && wdata_i[RESTART_BIT])); // R3
endmodule

// File: rtl/tri_timer_regs.sv
module tri_timer_regs
    import tri_timer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [CNT_W-1:0]             req_wdata,
    output logic                         rsp_valid,
    output logic [RDATA_W-1:0]           rsp_rdata,
    input  logic [NCH*CNT_W-1:0]         cnt_value,
    input  logic [NCH*CNT_W-1:0]         evt_value,
    input  logic [NCH*STAT_W-1:0]        evt_set,
    output logic [NCH*CTRL_W-1:0]        clk_ctrl,
    output logic [NCH*CTRL_W-1:0]        cnt_ctrl,
    output logic [NCH-1:0]               cnt_restart,
    output logic [NCH*CNT_W-1:0]         interval,
    output logic [NCH*MATCHES*CNT_W-1:0] match_val,
    output logic [NCH*ECTL_W-1:0]        evt_ctrl,
    output logic [NCH-1:0]               irq
);
    grp_e            grp;
    logic [NCH-1:0]  ch_oh;
    logic [CH_W-1:0] ch_idx;

    logic [CTRL_W-1:0]        clk_w   [NCH];
    logic [CTRL_W-1:0]        cnt_w   [NCH];
    logic [CNT_W-1:0]         ivl_w   [NCH];
    logic [MATCHES*CNT_W-1:0] match_w [NCH];
    logic [STAT_W-1:0]        ien_w   [NCH];
    logic [ECTL_W-1:0]        ectl_w  [NCH];
    logic [STAT_W-1:0]        stat_w  [NCH];

    tri_timer_decode #(.ADDR_W(ADDR_W)) decode_i (
        .addr_i   (req_addr),
        .grp_o    (grp),
        .ch_oh_o  (ch_oh),
        .ch_idx_o (ch_idx)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tri_timer_chan chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (req_valid && req_write && ch_oh[i]),
            .rd_i       (req_valid && !req_write && ch_oh[i]),
            .grp_i      (grp),
            .wdata_i    (req_wdata),
            .evt_set_i  (evt_set[i*STAT_W +: STAT_W]),
            .clk_ctrl_o (clk_w[i]),
            .cnt_ctrl_o (cnt_w[i]),
            .restart_o  (cnt_restart[i]),
            .interval_o (ivl_w[i]),
            .match_o    (match_w[i]),
            .ien_o      (ien_w[i]),
            .ectl_o     (ectl_w[i]),
            .stat_o     (stat_w[i]),
            .irq_o      (irq[i])
        );
        assign clk_ctrl[i*CTRL_W +: CTRL_W]                = clk_w[i];
        assign cnt_ctrl[i*CTRL_W +: CTRL_W]                = cnt_w[i];
        assign interval[i*CNT_W +: CNT_W]                  = ivl_w[i];
        assign match_val[i*MATCHES*CNT_W +: MATCHES*CNT_W] = match_w[i];
        assign evt_ctrl[i*ECTL_W +: ECTL_W]                = ectl_w[i];
    end

    top_st_t st_d, st_q;
    logic [RDATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch_idx == CH_W'(c) && ch_oh[c]) begin
                case (grp)
                    G_CLK:  rd_mux = RDATA_W'(clk_w[c]);
                    G_CNT:  rd_mux = RDATA_W'(cnt_w[c]);
                    G_VAL:  rd_mux = RDATA_W'(cnt_value[c*CNT_W +: CNT_W]);
                    G_IVL:  rd_mux = RDATA_W'(ivl_w[c]);
                    G_M1:   rd_mux = RDATA_W'(match_w[c][0*CNT_W +: CNT_W]);
                    G_M2:   rd_mux = RDATA_W'(match_w[c][1*CNT_W +: CNT_W]);
                    G_M3:   rd_mux = RDATA_W'(match_w[c][2*CNT_W +: CNT_W]);
                    G_STAT: rd_mux = RDATA_W'(stat_w[c]);
                    G_IEN:  rd_mux = RDATA_W'(ien_w[c]);
                    G_ECTL: rd_mux = RDATA_W'(ectl_w[c]);
                    G_EVAL: rd_mux = RDATA_W'(evt_value[c*CNT_W +: CNT_W]);
                    default: rd_mux = '0;
                endcase
            end
        end
        st_d.rsp_valid = req_valid && !req_write;
        st_d.rdata     = st_d.rsp_valid ? rd_mux : st_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rdata;

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R5
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R5
endmodule

// File: tb/tri_timer_regs_tb_top.sv
module tri_timer_regs_tb_top;
    localparam int AW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [47:0] cnt_value;
    logic [47:0] evt_value;
    logic [17:0] evt_set = '0;
    logic [17:0] clk_ctrl;
    logic [17:0] cnt_ctrl;
    logic [2:0]  cnt_restart;
    logic [47:0] interval;
    logic [143:0] match_val;
    logic [8:0]  evt_ctrl;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [11][3];

    always #2.5 clk = ~clk;

    tri_timer_regs #(.ADDR_W(AW)) dut_i (.*);

    assign cnt_value = {16'hC222, 16'hB111, 16'hA000};
    assign evt_value = {16'h0302, 16'h0301, 16'h0300};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] wmask(input int g);
        case (g)
            0, 8:       return 16'h003F;
            1:          return 16'h002F;
            3, 4, 5, 6: return 16'hFFFF;
            9:          return 16'h0007;
            default:    return 16'h0000;
        endcase
    endfunction

    function automatic logic [31:0] expect_rd(input int g, input int ch);
        case (g)
            2:  return {16'h0, cnt_value[ch*16 +: 16]};
            10: return {16'h0, evt_value[ch*16 +: 16]};
            default: return {16'h0, model[g][ch]};
        endcase
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R5 no response to write", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 read valid", {31'h0, rsp_valid}, 32'h1);
        d = rsp_rdata;
    endtask

    task automatic read_all(input string req);
        logic [31:0] d;
        for (int g = 0; g < 11; g++) begin
            for (int ch = 0; ch < 3; ch++) begin
                do_read(AW'(12*g + 4*ch), d);
                check(req, d, expect_rd(g, ch));
            end
        end
    endtask

    initial begin
        logic [31:0] d;
        for (int g = 0; g < 11; g++)
            for (int ch = 0; ch < 3; ch++)
                model[g][ch] = (g == 1) ? 16'h0021 : 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        check("R4 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R4 irq", {29'h0, irq}, 32'h0);
        check("R4 cnt_ctrl outputs", {14'h0, cnt_ctrl}, {14'h0, 6'h21, 6'h21, 6'h21});
        read_all("R4 R1 reset map");

        // R1 R2 R3 R9: sweep every register kind of every channel
        for (int g = 0; g < 11; g++) begin
            for (int ch = 0; ch < 3; ch++) begin
                logic [15:0] p;
                p = 16'h9C5A ^ 16'(g * 16'h0111) ^ 16'(ch * 16'h2213);
                if (g == 1 && ch == 1) p = p | 16'h0010;
                if (g == 1 && ch == 2) p = p & ~16'h0010;
                model[g][ch] = (wmask(g) == 0) ? model[g][ch] : (p & wmask(g));
                do_write(AW'(12*g + 4*ch), p);
                if (g == 1)
                    check("R3 restart pulse", {29'h0, cnt_restart},
                          {29'h0, 3'(p[4]) << ch});
                @(negedge clk);
                check("R3 restart single cycle", {29'h0, cnt_restart}, 32'h0);
                read_all("R1 R2 R9 sweep readback");
            end
        end
        for (int ch = 0; ch < 3; ch++) begin
            check("R2 interval out", {16'h0, interval[ch*16 +: 16]}, {16'h0, model[3][ch]});
            check("R2 match3 out", {16'h0, match_val[ch*48 + 32 +: 16]}, {16'h0, model[6][ch]});
            check("R2 clk_ctrl out", {26'h0, clk_ctrl[ch*6 +: 6]}, {26'h0, model[0][ch][5:0]});
            check("R2 evt_ctrl out", {29'h0, evt_ctrl[ch*3 +: 3]}, {29'h0, model[9][ch][2:0]});
        end

        // R10 unmapped and unaligned
        do_read(AW'(12'h084), d); check("R10 read 0x84", d, 32'h0);
        do_read(AW'(12'hFFC), d); check("R10 read 0xFFC", d, 32'h0);
        do_read(AW'(12'h025), d); check("R10 read unaligned", d, 32'h0);
        do_write(AW'(12'h084), 16'hFFFF);
        do_write(AW'(12'h025), 16'h1234);
        do_write(AW'(12'h032), 16'h4321);
        read_all("R10 writes ignored");

        // R8 R6: interrupt from status and enable
        do_write(AW'(12'h060), 16'h0000);
        do_write(AW'(12'h064), 16'h003F);
        do_write(AW'(12'h068), 16'h0001);
        @(negedge clk); evt_set = 18'h0 | (18'h04 << 6);
        @(negedge clk); evt_set = '0;
        check("R8 irq ch1", {29'h0, irq}, 32'h2);
        do_read(AW'(12'h058), d); check("R6 status read ch1", d, 32'h04);
        check("R8 irq after clear", {29'h0, irq}, 32'h0);
        do_read(AW'(12'h058), d); check("R6 status cleared", d, 32'h0);
        @(negedge clk); evt_set = 18'h08 << 12;
        @(negedge clk); evt_set = '0;
        check("R8 masked irq ch2", {29'h0, irq}, 32'h0);
        do_write(AW'(12'h068), 16'h0008);
        @(negedge clk);
        check("R8 enabled irq ch2", {29'h0, irq}, 32'h4);
        do_write(AW'(12'h05C), 16'h0000);
        check("R9 status write no effect", {29'h0, irq}, 32'h4);
        do_read(AW'(12'h05C), d); check("R6 status read ch2", d, 32'h08);

        // R7 coincident read and event
        @(negedge clk); evt_set = 18'h02;
        @(negedge clk); evt_set = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(12'h054); evt_set = 18'h20;
        @(negedge clk);
        req_valid = 1'b0; evt_set = '0;
        check("R7 old value returned", rsp_rdata, 32'h02);
        do_read(AW'(12'h054), d); check("R7 new event kept", d, 32'h20);
        do_read(AW'(12'h054), d); check("R7 cleared afterwards", d, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule